// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Receiver

This block is the serial configuration port of one device in a chain of devices that share a single configuration clock and bit stream. On every clock it samples one bit from `din`. Leading 1s are skipped as filler until the header preamble `0010` is recognised. The 24-bit length count that follows is then captured. Because the header and the length count are repeated on `dout`, every device further down the chain captures the same length value.

After the length count the block absorbs its own fixed number of data frames and holds `dout` high while doing so. From then on it repeats every incoming bit downstream. Independently of this, it counts configuration clocks from the release of `init_n`. On the clock whose count equals the captured length, every device in the chain begins start-up together. `done` rises first, the user-I/O enable follows two clocks later, and the finish flag follows a parameterised number of clocks after the match. A device whose clock stops early never reaches finish. Frames are counted but their contents are not stored.

Top module: `cfg_chain_rx`

## Requirements
- R1: While `rst_n` is low (asynchronous), or on any clock where `init_n` is low (synchronous), all state clears. After that clock `dout`=1 and `done`=`io_en`=`finish`=0, the clock count restarts from zero and the block searches for the preamble again.
- R2: Before the header, 1 bits are filler. The header is recognised on the clock where the last four sampled bits, oldest first, are 0,0,1,0. Every bit sampled before and during the preamble appears on `dout` exactly one clock later.
- R3: The LEN_W (24) bits after the preamble form the length count, most significant bit first. Each of them also appears on `dout` one clock later. The length is marked valid only after its last bit.
- R4: After the length count, the block absorbs FRAMES frames. Each frame is a start bit of 0 followed by FRAME_BITS data bits, and 1 bits between frames are ignored. For every bit sampled in this phase, including the last bit of the last frame, `dout` is 1 one clock later.
- R5: Once the own frames are complete, every later bit appears on `dout` one clock later, unchanged.
- R6: Clocks are counted from the first clock with `init_n` high; that clock counts as 1. `done` rises after clock number L, where L is the captured length. This happens only if the length was valid before that clock.
- R7: `io_en` rises IO_DLY (2) clocks after `done` rises.
- R8: `finish` rises FINISH_DLY (4) clocks after `done` rises, and not earlier. If the clock run ends or `init_n` falls sooner, `finish` is never seen high.
- R9: `done`, `io_en` and `finish` stay high once set, until `init_n` or `rst_n` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; one bit is sampled per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_n | input | 1 | Synchronous active-low memory-initialise; clears all state and the clock count |
| din | input | 1 | Serial configuration data in |
| dout | output | 1 | Registered serial data to the next device in the chain |
| done | output | 1 | Length-count match reached |
| io_en | output | 1 | User I/O released |
| finish | output | 1 | Start-up sequence complete |

## Verification
A wrong phase inside the receiver appears on `dout` one clock after the bit that caused it. Two examples: a preamble missed or falsely matched, and a frame miscounted by one bit. In each case `dout` either repeats a bit that should have been held at 1 or stays high when it should repeat. A clock count that is off by one, or a length shifted in the wrong order, moves the rising edge of `done` away from the expected clock, and the bench sees this on the edge itself. An error in the post-match counter shows as `io_en` or `finish` rising on the wrong clock. A stream cut short three clocks after the match must leave `finish` low.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;
  typedef enum logic [1:0] {
    PH_SEEK = 2'd0,
    PH_LEN  = 2'd1,
    PH_OWN  = 2'd2,
    PH_PASS = 2'd3
  } phase_t;

  localparam logic [3:0] HDR_PATTERN = 4'b0010;
endpackage

// File: rtl/cfg_frame_seq.sv
module cfg_frame_seq
  import cfg_chain_pkg::*;
#(
  parameter int LEN_W      = 24,
  parameter int FRAMES     = 3,
  parameter int FRAME_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_n,
  input  logic             din,
  output logic             dout,
  output logic [LEN_W-1:0] len,
  output logic             len_valid
);
  localparam int LB_W = $clog2(LEN_W);
  localparam int FB_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam int FC_W = $clog2(FRAMES + 1);
  localparam logic [LB_W-1:0] LAST_LB = LB_W'(LEN_W - 1);
  localparam logic [FB_W-1:0] LAST_FB = FB_W'(FRAME_BITS - 1);
  localparam logic [FC_W-1:0] LAST_FC = FC_W'(FRAMES - 1);

  phase_t           phase_q, phase_n;
  logic [2:0]       hist_q, hist_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic             lenok_q, lenok_n;
  logic [LB_W-1:0]  lbit_q, lbit_n;
  logic             infr_q, infr_n;
  logic [FB_W-1:0]  fbit_q, fbit_n;
  logic [FC_W-1:0]  fcnt_q, fcnt_n;
  logic             dout_q, dout_n;

  always_comb begin
    phase_n = phase_q;
    hist_n  = hist_q;
    len_n   = len_q;
    lenok_n = lenok_q;
    lbit_n  = lbit_q;
    infr_n  = infr_q;
    fbit_n  = fbit_q;
    fcnt_n  = fcnt_q;
    dout_n  = (phase_q == PH_OWN) ? 1'b1 : din;
    if (!init_n) begin
      phase_n = PH_SEEK;
      hist_n  = 3'b111;
      len_n   = '0;
      lenok_n = 1'b0;
      lbit_n  = '0;
      infr_n  = 1'b0;
      fbit_n  = '0;
      fcnt_n  = '0;
      dout_n  = 1'b1;
    end else begin
      case (phase_q)
        PH_SEEK: begin
          hist_n = {hist_q[1:0], din};
          if ({hist_q, din} == HDR_PATTERN) begin
            phase_n = PH_LEN;
            lbit_n  = '0;
          end
        end
        PH_LEN: begin
          len_n  = {len_q[LEN_W-2:0], din};
          lbit_n = lbit_q + 1'b1;
          if (lbit_q == LAST_LB) begin
            phase_n = PH_OWN;
            lenok_n = 1'b1;
            infr_n  = 1'b0;
            fcnt_n  = '0;
          end
        end
        PH_OWN: begin
          if (!infr_q) begin
            if (!din) begin
              infr_n = 1'b1;
              fbit_n = '0;
            end
          end else begin
            fbit_n = fbit_q + 1'b1;
            if (fbit_q == LAST_FB) begin
              infr_n = 1'b0;
              fcnt_n = fcnt_q + 1'b1;
              if (fcnt_q == LAST_FC) phase_n = PH_PASS;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SEEK;
      hist_q  <= 3'b111;
      len_q   <= '0;
      lenok_q <= 1'b0;
      lbit_q  <= '0;
      infr_q  <= 1'b0;
      fbit_q  <= '0;
      fcnt_q  <= '0;
      dout_q  <= 1'b1;
    end else begin
      phase_q <= phase_n;
      hist_q  <= hist_n;
      len_q   <= len_n;
      lenok_q <= lenok_n;
      lbit_q  <= lbit_n;
      infr_q  <= infr_n;
      fbit_q  <= fbit_n;
      fcnt_q  <= fcnt_n;
      dout_q  <= dout_n;
    end
  end

  assign dout      = dout_q;
  assign len       = len_q;
  assign len_valid = lenok_q;

  AST_OWN_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OWN) |=> dout); // R4
  AST_PASS_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PASS && init_n) |=> (dout == $past(din))); // R5
  AST_LEN_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(len_valid) |-> ($past(phase_q) == PH_LEN)); // R3
endmodule

// File: rtl/cfg_clk_counter.sv
module cfg_clk_counter #(
  parameter int LEN_W      = 24,
  parameter int IO_DLY     = 2,
  parameter int FINISH_DLY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_n,
  input  logic [LEN_W-1:0] len,
  input  logic             len_valid,
  output logic             done,
  output logic             io_en,
  output logic             finish
);
  localparam int PC_W = $clog2(FINISH_DLY + 1);
  localparam logic [PC_W-1:0] PC_IO  = PC_W'(IO_DLY);
  localparam logic [PC_W-1:0] PC_FIN = PC_W'(FINISH_DLY);

  logic [LEN_W-1:0] cnt_q, cnt_n, cnt_inc;
  logic             done_q, done_n;
  logic [PC_W-1:0]  pc_q, pc_n;
  logic             match;

  assign cnt_inc = cnt_q + 1'b1;
  assign match   = len_valid && !done_q && (cnt_inc == len);

  always_comb begin
    cnt_n  = cnt_q;
    done_n = done_q;
    pc_n   = pc_q;
    if (!init_n) begin
      cnt_n  = '0;
      done_n = 1'b0;
      pc_n   = '0;
    end else begin
      if (!done_q && cnt_q != '1) cnt_n = cnt_inc;
      if (match) begin
        done_n = 1'b1;
        pc_n   = '0;
      end else if (done_q && pc_q != PC_FIN) begin
        pc_n = pc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      pc_q   <= '0;
    end else begin
      cnt_q  <= cnt_n;
      done_q <= done_n;
      pc_q   <= pc_n;
    end
  end

  assign done   = done_q;
  assign io_en  = done_q && (pc_q >= PC_IO);
  assign finish = done_q && (pc_q == PC_FIN);

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && init_n) |=> done); // R9
  AST_IOEN_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> done); // R7
  AST_FINISH_NEEDS_IOEN: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> io_en); // R8
  AST_DONE_NEEDS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> len_valid); // R6
endmodule

// File: rtl/cfg_chain_rx.sv
module cfg_chain_rx #(
  parameter int LEN_W      = 24,
  parameter int FRAMES     = 3,
  parameter int FRAME_BITS = 8,
  parameter int IO_DLY     = 2,
  parameter int FINISH_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_n,
  input  logic din,
  output logic dout,
  output logic done,
  output logic io_en,
  output logic finish
);
  logic [LEN_W-1:0] len;
  logic             len_valid;

  cfg_frame_seq #(
    .LEN_W(LEN_W), .FRAMES(FRAMES), .FRAME_BITS(FRAME_BITS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .din(din),
    .dout(dout), .len(len), .len_valid(len_valid)
  );

  cfg_clk_counter #(
    .LEN_W(LEN_W), .IO_DLY(IO_DLY), .FINISH_DLY(FINISH_DLY)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .len(len),
    .len_valid(len_valid), .done(done), .io_en(io_en), .finish(finish)
  );
endmodule

// File: tb/cfg_chain_rx_test.sv
module cfg_chain_rx_test;
  localparam int LEN_W = 24, FRAMES = 3, FRAME_BITS = 8, IO_DLY = 2, FINISH_DLY = 4;

  logic clk = 1'b0, rst_n = 1'b0, init_n = 1'b1, din = 1'b1;
  logic dout, done, io_en, finish;
  int vectors = 0, fails = 0;
  int unsigned seed = 32'h1234_5678;

  // reference model state
  int m_ph = 0;  // 0 seek, 1 length, 2 own frames, 3 forward
  bit hq[$];
  int m_len = 0, m_lbits = 0, m_clk = 0, m_since = 0;
  bit m_lenok = 0, m_inf = 0, m_done = 0, m_wasdone = 0;
  int m_fbits = 0, m_frames = 0;
  bit e_dout = 1;
  string dtag = "R1";
  bit finish_seen = 0;

  always #4 clk = ~clk;

  cfg_chain_rx #(.LEN_W(LEN_W), .FRAMES(FRAMES), .FRAME_BITS(FRAME_BITS),
                 .IO_DLY(IO_DLY), .FINISH_DLY(FINISH_DLY)) uut (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .din(din),
    .dout(dout), .done(done), .io_en(io_en), .finish(finish));

  function automatic bit rbit();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[16];
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_ph = 0; hq.delete(); m_len = 0; m_lbits = 0; m_clk = 0; m_since = 0;
    m_lenok = 0; m_inf = 0; m_done = 0; m_wasdone = 0; m_fbits = 0; m_frames = 0;
    e_dout = 1; dtag = "R1";
  endtask

  task automatic model_step(bit b, bit i);
    if (!i) begin model_clear(); return; end
    m_wasdone = m_done;
    m_clk++;
    dtag   = (m_ph == 0) ? "R2" : (m_ph == 1) ? "R3" : (m_ph == 2) ? "R4" : "R5";
    e_dout = (m_ph == 2) ? 1'b1 : b;
    if (m_done) m_since++;
    else if (m_lenok && m_clk == m_len) begin m_done = 1; m_since = 0; end
    case (m_ph)
      0: begin
        hq.push_back(b);
        if (hq.size() > 4) void'(hq.pop_front());
        if (hq.size() == 4 && hq[0] == 0 && hq[1] == 0 && hq[2] == 1 && hq[3] == 0) begin
          m_ph = 1; m_lbits = 0; m_len = 0;
        end
      end
      1: begin
        m_len = m_len * 2 + b;
        m_lbits++;
        if (m_lbits == LEN_W) begin m_ph = 2; m_lenok = 1; m_inf = 0; m_frames = 0; end
      end
      2: begin
        if (!m_inf) begin
          if (!b) begin m_inf = 1; m_fbits = 0; end
        end else begin
          m_fbits++;
          if (m_fbits == FRAME_BITS) begin
            m_inf = 0; m_frames++;
            if (m_frames == FRAMES) m_ph = 3;
          end
        end
      end
      default: ;
    endcase
  endtask

  task automatic compare();
    chk(dtag, "dout", dout, e_dout);
    chk(m_wasdone ? "R9" : "R6", "done", done, m_done);
    chk("R7", "io_en", io_en, m_done && m_since >= IO_DLY);
    chk("R8", "finish", finish, m_done && m_since >= FINISH_DLY);
    if (finish) finish_seen = 1;
  endtask

  task automatic cyc(bit b, bit i);
    din = b; init_n = i;
    @(posedge clk);
    model_step(b, i);
    @(negedge clk);
    compare();
  endtask

  // header, own frames, then random bits until total clocks are used
  task automatic send_stream(int filler, int len, int gap, int total);
    int used = 0;
    for (int k = 0; k < filler; k++) begin cyc(1'b1, 1'b1); used++; end
    cyc(1'b0, 1'b1); cyc(1'b0, 1'b1); cyc(1'b1, 1'b1); cyc(1'b0, 1'b1);
    used += 4;
    for (int k = LEN_W - 1; k >= 0; k--) begin cyc(len[k], 1'b1); used++; end
    for (int f = 0; f < FRAMES; f++) begin
      for (int g = 0; g < gap; g++) begin cyc(1'b1, 1'b1); used++; end
      cyc(1'b0, 1'b1); used++;
      for (int k = 0; k < FRAME_BITS; k++) begin cyc(rbit(), 1'b1); used++; end
    end
    while (used < total) begin cyc(rbit(), 1'b1); used++; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "dout in reset", dout, 1'b1);
    chk("R1", "done in reset", done, 1'b0);
    chk("R1", "finish in reset", finish, 1'b0);
    rst_n = 1'b1;
    model_clear();

    // R6 R7 R8: full stream with filler and gaps between frames
    send_stream(5, 80, 2, 90);
    chk("R6", "done after stream A", done, 1'b1);
    chk("R7", "io_en after stream A", io_en, 1'b1);
    chk("R8", "finish after stream A", finish, 1'b1);

    // R1: init clears everything
    cyc(1'b1, 1'b0);
    chk("R1", "done after init", done, 1'b0);
    chk("R1", "io_en after init", io_en, 1'b0);

    // R2: near-miss bits before the preamble
    cyc(1'b1, 1'b1); cyc(1'b0, 1'b1); cyc(1'b1, 1'b1); cyc(1'b1, 1'b1);
    send_stream(0, 75, 0, 80);
    chk("R6", "done after stream B", done, 1'b1);

    // R8: clock run ends three clocks after the match
    cyc(1'b1, 1'b0);
    finish_seen = 0;
    send_stream(0, 64, 1, 67);
    chk("R6", "done in short run", done, 1'b1);
    chk("R8", "finish never seen in short run", finish_seen, 1'b0);
    cyc(1'b0, 1'b0);
    chk("R1", "finish after init", finish, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule